// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits on the host write path of a byte-wide nonvolatile memory and watches every write cycle for fixed address/data unlock sequences. A short sequence (two key writes, then a command write) either opens a protected page load, enters identifier mode or leaves it. A long sequence (two key writes, an extend command, two more key writes, then a command write) starts a chip erase, turns write protection off, or enters identifier mode by an alternate path. Only the low 15 address bits take part in the compare. Upper address bits are ignored.

Protection starts off. The page-load command turns it on and opens one page load window. While protection is on, any write that is not part of a valid sequence is rejected and locks the block out for a fixed number of cycles. While protection is off, such a write is passed through as an ordinary data load. A write that breaks a sequence part way returns the decoder to idle and is then handled as a stray write. In identifier mode, reads at address 0 and 1 return the manufacturer code and the device code. The array and the page buffer lie outside this block. It only emits the load-enable and erase-start pulses that drive them.

The decoder states are Idle, Key1 (first key seen), Key2 (both keys seen), Ext1 (extend command seen), Ext2 and Ext3 (the second pair of keys seen), Load (page load window open) and Lockout (rejected write being penalised). The transitions are key-advance (Idle→Key1→Key2, Ext1→Ext2→Ext3), extend (Key2→Ext1), open-load (Key2→Load), short-command (Key2→Idle), long-command (Ext3→Idle), abort (any sequence state→Idle on a mismatched write, protection off), reject (Idle or any sequence state→Lockout, protection on), load-timeout (Load→Idle) and lockout-expiry (Lockout→Idle).

Top module: `unlock_seq_decoder`

## Requirements
- R1: After reset, seq_state is 0 (Idle), and prot_on, id_mode, locked, load_en and erase_go are all 0.
- R2: A write of AAh to address 5555h moves Idle to Key1 (seq_state 1). A following write of 55h to 2AAAh moves to Key2 (seq_state 2). Only address bits 14..0 are compared.
- R3: In Key2, a write of A0h to 5555h sets prot_on and enters Load (seq_state 6). Every write made while in Load gives a load_en pulse that is high for exactly the one cycle after the write.
- R4: Load returns to Idle when GAP_CYCLES cycles pass with no write. A write that arrives GAP_CYCLES cycles after the previous one or sooner keeps the window open.
- R5: While prot_on is 0, a write that matches no expected step (in Idle, or in any of Key1, Key2, Ext1, Ext2, Ext3) sends the decoder to Idle and gives a one-cycle load_en pulse.
- R6: While prot_on is 1, such a write enters Lockout (seq_state 7) with locked high for exactly LOCK_CYCLES cycles, then returns to Idle.
- R7: Writes during Lockout are ignored. They change neither prot_on nor id_mode, and they give no load_en pulse.
- R8: In Key2, a write of 80h to 5555h enters Ext1 (seq_state 3). AAh to 5555h then enters Ext2 (4), and 55h to 2AAAh then enters Ext3 (5). In Ext3, a write of 10h to 5555h gives a one-cycle erase_go pulse and returns to Idle.
- R9: In Ext3, a write of 20h to 5555h clears prot_on and returns to Idle.
- R10: id_mode is set by 90h to 5555h in Key2, or by 60h to 5555h in Ext3.
- R11: While id_mode is 1, a read address whose bits 14..0 are 0 gives id_hit 1 and id_rdata BFh. Bits 14..0 equal to 1 give id_hit 1 and id_rdata DEV_CODE. Any other address, or id_mode 0, gives id_hit 0 and id_rdata 00h.
- R12: In Key2, a write of F0h to 5555h clears id_mode and returns to Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_addr | input | ADDR_W | Write address; bits 14..0 compared |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | ADDR_W | Read address for identifier codes |
| prot_on | output | 1 | Global write protection flag |
| load_en | output | 1 | One-cycle pulse: write accepted as a page data load |
| erase_go | output | 1 | One-cycle pulse: start chip erase |
| id_mode | output | 1 | Identifier mode active |
| id_hit | output | 1 | Read address hits an identifier location |
| id_rdata | output | 8 | Identifier code for rd_addr |
| locked | output | 1 | Lockout penalty in progress |
| seq_state | output | 3 | Decoder state code (0 Idle .. 7 Lockout) |

## Verification
Every write result is registered: seq_state, prot_on, id_mode, load_en and erase_go change on the edge that captures the write. They are due one cycle after the strobe, and the pulses drop one cycle later. Identifier reads are combinational from the registered mode bit, so they are valid in the same cycle as rd_addr. The load window and the lockout are counted in whole cycles from the capturing edge. The bench probes each boundary on both sides, at GAP_CYCLES-1 versus GAP_CYCLES idle cycles and at LOCK_CYCLES-1 versus LOCK_CYCLES cycles. Inputs change on the falling edge and outputs are sampled on the next falling edge, which puts each sample exactly one capturing edge after its stimulus.

// File: rtl/unlock_pkg.sv
`timescale 1ns/1ps
package unlock_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_KEY1 = 3'd1,
        ST_KEY2 = 3'd2,
        ST_EXT1 = 3'd3,
        ST_EXT2 = 3'd4,
        ST_EXT3 = 3'd5,
        ST_LOAD = 3'd6,
        ST_LOCK = 3'd7
    } seq_st_t;

    localparam int          CMP_W     = 15;
    localparam logic [14:0] ADR_A     = 15'h5555;
    localparam logic [14:0] ADR_B     = 15'h2AAA;
    localparam logic [7:0]  KEY_A     = 8'hAA;
    localparam logic [7:0]  KEY_B     = 8'h55;
    localparam logic [7:0]  OP_WRITE  = 8'hA0;
    localparam logic [7:0]  OP_EXT    = 8'h80;
    localparam logic [7:0]  OP_ID_IN  = 8'h90;
    localparam logic [7:0]  OP_ID_OUT = 8'hF0;
    localparam logic [7:0]  OP_ERASE  = 8'h10;
    localparam logic [7:0]  OP_UNPROT = 8'h20;
    localparam logic [7:0]  OP_ID_ALT = 8'h60;
    localparam logic [7:0]  MFR_CODE  = 8'hBF;

    typedef struct packed {
        logic key_a;
        logic key_b;
        logic op_write;
        logic op_ext;
        logic op_id_in;
        logic op_id_out;
        logic op_erase;
        logic op_unprot;
        logic op_id_alt;
    } hit_t;

endpackage

// File: rtl/unlock_match.sv
`timescale 1ns/1ps
module unlock_match
    import unlock_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output hit_t              hit
);

    logic [CMP_W-1:0] low;
    logic             at_a;
    logic             at_b;

    assign low  = addr[CMP_W-1:0];
    assign at_a = (low == ADR_A);
    assign at_b = (low == ADR_B);

    generate
        if (ADDR_W > CMP_W) begin : g_upper
            logic unused_hi;
            assign unused_hi = ^addr[ADDR_W-1:CMP_W];
        end
    endgenerate

    always_comb begin
        hit           = '0;
        hit.key_a     = at_a && (data == KEY_A);
        hit.key_b     = at_b && (data == KEY_B);
        hit.op_write  = at_a && (data == OP_WRITE);
        hit.op_ext    = at_a && (data == OP_EXT);
        hit.op_id_in  = at_a && (data == OP_ID_IN);
        hit.op_id_out = at_a && (data == OP_ID_OUT);
        hit.op_erase  = at_a && (data == OP_ERASE);
        hit.op_unprot = at_a && (data == OP_UNPROT);
        hit.op_id_alt = at_a && (data == OP_ID_ALT);
    end

endmodule

// File: rtl/unlock_timer.sv
`timescale 1ns/1ps
module unlock_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire,
    output logic busy
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(LIMIT);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == CW'(1));
    assign busy   = (cnt != '0);

endmodule

// File: rtl/unlock_id_port.sv
`timescale 1ns/1ps
module unlock_id_port
    import unlock_pkg::*;
#(
    parameter int         ADDR_W   = 18,
    parameter logic [7:0] DEV_CODE = 8'h10
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              id_hit,
    output logic [7:0]        id_rdata
);

    logic [CMP_W-1:0] low;

    assign low = rd_addr[CMP_W-1:0];

    generate
        if (ADDR_W > CMP_W) begin : g_upper
            logic unused_hi;
            assign unused_hi = ^rd_addr[ADDR_W-1:CMP_W];
        end
    endgenerate

    always_comb begin
        id_hit   = id_mode && (low[CMP_W-1:1] == '0);
        id_rdata = 8'h00;
        if (id_hit) begin
            id_rdata = low[0] ? DEV_CODE : MFR_CODE;
        end
    end

endmodule

// File: rtl/unlock_fsm.sv
`timescale 1ns/1ps
module unlock_fsm
    import unlock_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_en,
    input  hit_t    hit,
    input  logic    gap_exp,
    input  logic    lock_exp,
    output seq_st_t state,
    output logic    prot_on,
    output logic    id_mode,
    output logic    load_en,
    output logic    erase_go,
    output logic    gap_go,
    output logic    lock_go
);

    seq_st_t nxt;
    logic    stray;
    logic    ev_load;
    logic    ev_prot_set;
    logic    ev_prot_clr;
    logic    ev_id_in;
    logic    ev_id_out;
    logic    ev_erase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt         = state;
        stray       = 1'b0;
        ev_load     = 1'b0;
        ev_prot_set = 1'b0;
        ev_prot_clr = 1'b0;
        ev_id_in    = 1'b0;
        ev_id_out   = 1'b0;
        ev_erase    = 1'b0;
        lock_go     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (wr_en) begin
                    if (hit.key_a) nxt = ST_KEY1;
                    else           stray = 1'b1;
                end
            end
            ST_KEY1: begin
                if (wr_en) begin
                    if (hit.key_b) nxt = ST_KEY2;
                    else           stray = 1'b1;
                end
            end
            ST_KEY2: begin
                if (wr_en) begin
                    if (hit.op_write) begin
                        ev_prot_set = 1'b1;
                        nxt         = ST_LOAD;
                    end else if (hit.op_ext) begin
                        nxt = ST_EXT1;
                    end else if (hit.op_id_in) begin
                        ev_id_in = 1'b1;
                        nxt      = ST_IDLE;
                    end else if (hit.op_id_out) begin
                        ev_id_out = 1'b1;
                        nxt       = ST_IDLE;
                    end else begin
                        stray = 1'b1;
                    end
                end
            end
            ST_EXT1: begin
                if (wr_en) begin
                    if (hit.key_a) nxt = ST_EXT2;
                    else           stray = 1'b1;
                end
            end
            ST_EXT2: begin
                if (wr_en) begin
                    if (hit.key_b) nxt = ST_EXT3;
                    else           stray = 1'b1;
                end
            end
            ST_EXT3: begin
                if (wr_en) begin
                    if (hit.op_erase) begin
                        ev_erase = 1'b1;
                        nxt      = ST_IDLE;
                    end else if (hit.op_unprot) begin
                        ev_prot_clr = 1'b1;
                        nxt         = ST_IDLE;
                    end else if (hit.op_id_alt) begin
                        ev_id_in = 1'b1;
                        nxt      = ST_IDLE;
                    end else begin
                        stray = 1'b1;
                    end
                end
            end
            ST_LOAD: begin
                if (wr_en)        ev_load = 1'b1;
                else if (gap_exp) nxt = ST_IDLE;
            end
            ST_LOCK: begin
                if (lock_exp) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
        if (stray) begin
            if (prot_on) begin
                nxt     = ST_LOCK;
                lock_go = 1'b1;
            end else begin
                nxt     = ST_IDLE;
                ev_load = 1'b1;
            end
        end
    end

    assign gap_go = ev_prot_set || ((state == ST_LOAD) && wr_en);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_on  <= 1'b0;
            id_mode  <= 1'b0;
            load_en  <= 1'b0;
            erase_go <= 1'b0;
        end else begin
            if (ev_prot_set)      prot_on <= 1'b1;
            else if (ev_prot_clr) prot_on <= 1'b0;
            if (ev_id_in)         id_mode <= 1'b1;
            else if (ev_id_out)   id_mode <= 1'b0;
            load_en  <= ev_load;
            erase_go <= ev_erase;
        end
    end

endmodule

// File: rtl/unlock_seq_decoder.sv
`timescale 1ns/1ps
module unlock_seq_decoder
    import unlock_pkg::*;
#(
    parameter int         ADDR_W      = 18,
    parameter logic [7:0] DEV_CODE    = 8'h10,
    parameter int         GAP_CYCLES  = 25000,
    parameter int         LOCK_CYCLES = 37500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prot_on,
    output logic              load_en,
    output logic              erase_go,
    output logic              id_mode,
    output logic              id_hit,
    output logic [7:0]        id_rdata,
    output logic              locked,
    output logic [2:0]        seq_state
);

    hit_t    hit;
    seq_st_t state;
    logic    gap_go;
    logic    gap_exp;
    logic    lock_go;
    logic    lock_exp;
    logic    gap_busy_unused;
    logic    lock_busy_unused;

    unlock_match #(.ADDR_W(ADDR_W)) u_match (
        .addr (wr_addr),
        .data (wr_data),
        .hit  (hit)
    );

    unlock_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .hit      (hit),
        .gap_exp  (gap_exp),
        .lock_exp (lock_exp),
        .state    (state),
        .prot_on  (prot_on),
        .id_mode  (id_mode),
        .load_en  (load_en),
        .erase_go (erase_go),
        .gap_go   (gap_go),
        .lock_go  (lock_go)
    );

    unlock_timer #(.LIMIT(GAP_CYCLES)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (gap_go),
        .expire (gap_exp),
        .busy   (gap_busy_unused)
    );

    unlock_timer #(.LIMIT(LOCK_CYCLES)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (lock_go),
        .expire (lock_exp),
        .busy   (lock_busy_unused)
    );

    unlock_id_port #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_id (
        .id_mode  (id_mode),
        .rd_addr  (rd_addr),
        .id_hit   (id_hit),
        .id_rdata (id_rdata)
    );

    assign locked    = (state == ST_LOCK);
    assign seq_state = state;

endmodule

// File: rtl/unlock_seq_checker.sv
`timescale 1ns/1ps
module unlock_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       prot_on,
    input logic       load_en,
    input logic       erase_go,
    input logic       id_mode,
    input logic       locked,
    input logic [2:0] seq_state
);

    p_prot_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> (seq_state == 3'd6));

    p_load_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> $past(wr_en));

    p_lock_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked || (seq_state == 3'd0)));

    p_lock_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd7) |=> ($stable(prot_on) && $stable(id_mode) && !load_en));

    p_erase_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> !erase_go);

    p_erase_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> ($past(seq_state) == 3'd5));

    p_prot_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> (($past(seq_state) == 3'd5) && (seq_state == 3'd0)));

    p_id_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> ($past(wr_en) && (seq_state == 3'd0)));

endmodule

bind unlock_seq_decoder unlock_seq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .prot_on   (prot_on),
    .load_en   (load_en),
    .erase_go  (erase_go),
    .id_mode   (id_mode),
    .locked    (locked),
    .seq_state (seq_state)
);

// File: tb/sim_unlock_seq_decoder.sv
`timescale 1ns/1ps
module sim_unlock_seq_decoder;

    localparam int AW   = 18;
    localparam int GAP  = 8;
    localparam int LOCK = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          prot_on, load_en, erase_go, id_mode, id_hit, locked;
    logic [7:0]    id_rdata;
    logic [2:0]    seq_state;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    unlock_seq_decoder #(
        .ADDR_W(AW), .DEV_CODE(8'h10), .GAP_CYCLES(GAP), .LOCK_CYCLES(LOCK)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .prot_on(prot_on),
        .load_en(load_en), .erase_go(erase_go), .id_mode(id_mode),
        .id_hit(id_hit), .id_rdata(id_rdata), .locked(locked),
        .seq_state(seq_state)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic seq3(input logic [7:0] op);
        wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, op);
    endtask

    task automatic seq6(input logic [7:0] op);
        seq3(8'h80);
        wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, op);
    endtask

    task automatic t_reset;
        chk("R1 state", {5'd0, seq_state}, 8'd0);
        chk("R1 prot", {7'd0, prot_on}, 8'd0);
        chk("R1 id", {7'd0, id_mode}, 8'd0);
        chk("R1 locked", {7'd0, locked}, 8'd0);
        chk("R1 pulses", {6'd0, load_en, erase_go}, 8'd0);
    endtask

    task automatic t_plain_and_abort;
        wr(18'h01234, 8'h5A);
        chk("R5 plain load", {7'd0, load_en}, 8'd1);
        chk("R5 plain state", {5'd0, seq_state}, 8'd0);
        wr(18'h05555, 8'hAA);
        chk("R2 key1", {5'd0, seq_state}, 8'd1);
        chk("R2 key1 no load", {7'd0, load_en}, 8'd0);
        wr(18'h02AAA, 8'h00);
        chk("R5 abort state", {5'd0, seq_state}, 8'd0);
        chk("R5 abort load", {7'd0, load_en}, 8'd1);
        idle(1);
        chk("R5 load one cycle", {7'd0, load_en}, 8'd0);
    endtask

    task automatic t_id_upper_bits;
        wr(18'h3D555, 8'hAA);
        chk("R2 upper key1", {5'd0, seq_state}, 8'd1);
        wr(18'h22AAA, 8'h55);
        chk("R2 upper key2", {5'd0, seq_state}, 8'd2);
        wr(18'h0D555, 8'h90);
        chk("R10 id entry", {7'd0, id_mode}, 8'd1);
        chk("R10 id state", {5'd0, seq_state}, 8'd0);
    endtask

    task automatic t_id_read;
        rd_addr = 18'h00000; #1;
        chk("R11 mfr hit", {7'd0, id_hit}, 8'd1);
        chk("R11 mfr code", id_rdata, 8'hBF);
        rd_addr = 18'h00001; #1;
        chk("R11 dev code", id_rdata, 8'h10);
        rd_addr = 18'h00002; #1;
        chk("R11 other hit", {7'd0, id_hit}, 8'd0);
        chk("R11 other data", id_rdata, 8'h00);
        rd_addr = 18'h28000; #1;
        chk("R11 upper ignored", id_rdata, 8'hBF);
        rd_addr = 18'h00000;
        @(negedge clk);
    endtask

    task automatic t_id_exit_alt;
        seq3(8'hF0);
        chk("R12 id exit", {7'd0, id_mode}, 8'd0);
        #1;
        chk("R11 no hit outside", {7'd0, id_hit}, 8'd0);
        chk("R11 zero outside", id_rdata, 8'h00);
        seq3(8'h80);
        chk("R8 ext1", {5'd0, seq_state}, 8'd3);
        wr(18'h05555, 8'hAA);
        chk("R8 ext2", {5'd0, seq_state}, 8'd4);
        wr(18'h02AAA, 8'h55);
        chk("R8 ext3", {5'd0, seq_state}, 8'd5);
        wr(18'h05555, 8'h60);
        chk("R10 alt entry", {7'd0, id_mode}, 8'd1);
        seq3(8'hF0);
        chk("R12 exit again", {7'd0, id_mode}, 8'd0);
    endtask

    task automatic t_protect_load;
        seq3(8'hA0);
        chk("R3 prot set", {7'd0, prot_on}, 8'd1);
        chk("R3 load state", {5'd0, seq_state}, 8'd6);
        wr(18'h01000, 8'h11);
        chk("R3 load pulse", {7'd0, load_en}, 8'd1);
        idle(GAP - 1);
        chk("R4 window open", {5'd0, seq_state}, 8'd6);
        wr(18'h01001, 8'h22);
        chk("R4 late load", {7'd0, load_en}, 8'd1);
        idle(GAP - 1);
        chk("R4 still open", {5'd0, seq_state}, 8'd6);
        idle(1);
        chk("R4 window closed", {5'd0, seq_state}, 8'd0);
    endtask

    task automatic t_lockout;
        wr(18'h00100, 8'h33);
        chk("R6 lock state", {5'd0, seq_state}, 8'd7);
        chk("R6 locked", {7'd0, locked}, 8'd1);
        chk("R6 no load", {7'd0, load_en}, 8'd0);
        for (int k = 0; k < 6; k++) begin
            case (k)
                0, 3:    wr(18'h05555, 8'hAA);
                1, 4:    wr(18'h02AAA, 8'h55);
                2:       wr(18'h05555, 8'h80);
                default: wr(18'h05555, 8'h20);
            endcase
            chk("R7 ignored no load", {7'd0, load_en}, 8'd0);
        end
        chk("R7 prot kept", {7'd0, prot_on}, 8'd1);
        idle(LOCK - 7);
        chk("R6 still locked", {7'd0, locked}, 8'd1);
        idle(1);
        chk("R6 lock over", {5'd0, seq_state}, 8'd0);
        chk("R7 prot after lock", {7'd0, prot_on}, 8'd1);
    endtask

    task automatic t_erase_disable;
        seq6(8'h10);
        chk("R8 erase pulse", {7'd0, erase_go}, 8'd1);
        chk("R8 erase idle", {5'd0, seq_state}, 8'd0);
        idle(1);
        chk("R8 erase one cycle", {7'd0, erase_go}, 8'd0);
        seq6(8'h20);
        chk("R9 prot cleared", {7'd0, prot_on}, 8'd0);
        chk("R9 state idle", {5'd0, seq_state}, 8'd0);
        wr(18'h00200, 8'h44);
        chk("R9 plain load again", {7'd0, load_en}, 8'd1);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_plain_and_abort;
        t_id_upper_bits;
        t_id_read;
        t_id_exit_alt;
        t_protect_load;
        t_lockout;
        t_erase_disable;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule